// File: doc/BRIEF.md
# Dual-Queue Priority Conversion Scheduler

This block decides which of two command queues drives a single analog-to-digital converter. Each queue has a trigger input, a mode-enable input, a command pointer and a status state. An external command table gives back two flags for the entry at each pointer: pause and end-of-queue. The block asks the converter for a conversion with a one-cycle start pulse and retires a command word when the converter answers with a one-cycle done pulse.

Queue 1 has strict priority. A trigger on queue 1 while queue 2 owns the converter cancels the queue 2 conversion with an abort pulse and suspends queue 2. A trigger on queue 2 while queue 1 runs leaves queue 2 waiting in a trigger-pending state. When queue 1 finishes or pauses, queue 2 is handed the converter after a fixed delay. A synchronous stop input returns both queues to idle and rewinds both pointers.

The converter, the result storage, the trigger sources and any register access are outside this block.

Top module: `dual_queue_sched`

## Requirements
- R1: An idle or paused queue becomes active (queue 1 field 10, queue 2 field 010) on a trigger pulse only while its mode-enable input is 1. A trigger with mode-enable 0 changes neither status nor pointer.
- R2: At no cycle are both queues active. Both queues may be paused at once, which reads 01_001.
- R3: When a command word with pause=1 and end-of-queue=0 completes, its queue goes to paused and its pointer advances by one. Its next accepted trigger resumes at that pointer.
- R4: When a command word with end-of-queue=1 completes, its queue goes to idle and its pointer returns to 0. End-of-queue overrides pause.
- R5: A queue 1 trigger accepted while queue 2 is active sets the status to 10_011. If a queue 2 conversion is in flight, conv_abort pulses for one cycle and no done is taken from it.
- R6: A suspended queue 2 reads active in the first cycle after queue 1 leaves active. It restarts the aborted word at the pointer it held when aborted.
- R7: A queue 2 trigger accepted while queue 1 is active, or is being triggered in the same cycle, sets queue 2 to trigger pending (100). Queue 1 has no such state.
- R8: After queue 1 leaves active with queue 2 trigger pending, queue 2 reads 100 for exactly 2 cycles and then 010. No queue 2 conversion starts during those 2 cycles.
- R9: A trigger for a queue that is already active, suspended or trigger pending is ignored. The queue's run issues the same conversions it would issue without that trigger.
- R10: Stop sets the status to 00_000 and both pointers to 0 in the next cycle. If a conversion is in flight, stop also pulses conv_abort.
- R11: Status layout: queue_status[4:3] is queue 1 (idle 00, paused 01, active 10) and queue_status[2:0] is queue 2 (idle 000, paused 001, active 010, suspended 011, trigger pending 100). After reset the status is 00_000.
- R12: conv_start pulses for one cycle when a queue is active and no conversion is in flight. In that cycle conv_qsel gives the queue (0 = queue 1, 1 = queue 2) and conv_ptr gives that queue's pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop | input | 1 | Synchronous stop: return both queues to idle |
| q1_mode_en | input | 1 | Queue 1 operating mode valid |
| q1_trig | input | 1 | Queue 1 trigger event |
| q1_cmd_pause | input | 1 | Pause flag of the queue 1 word at q1_ptr |
| q1_cmd_eoq | input | 1 | End-of-queue flag of the queue 1 word at q1_ptr |
| q2_mode_en | input | 1 | Queue 2 operating mode valid |
| q2_trig | input | 1 | Queue 2 trigger event |
| q2_cmd_pause | input | 1 | Pause flag of the queue 2 word at q2_ptr |
| q2_cmd_eoq | input | 1 | End-of-queue flag of the queue 2 word at q2_ptr |
| conv_done | input | 1 | Converter finished the conversion in flight |
| q1_ptr | output | PTR_W | Queue 1 command pointer |
| q2_ptr | output | PTR_W | Queue 2 command pointer |
| conv_start | output | 1 | Start a conversion |
| conv_qsel | output | 1 | Queue that owns the started conversion |
| conv_ptr | output | PTR_W | Command pointer of the started conversion |
| conv_abort | output | 1 | Cancel the conversion in flight |
| queue_status | output | 5 | Packed status {queue 1, queue 2} |

## Verification
The embedded properties assume the converter behaves: conv_done is a single-cycle pulse that answers exactly one earlier conv_start, and it never arrives in the same cycle as an abort or a stop. They also assume the command flag inputs always describe the word at the current pointer of their queue. The bench meets these assumptions with a converter model that raises done a fixed number of cycles after each start and drops the pending done on abort or stop. Its command tables are looked up by the pointers the block exports, and triggers are driven as single-cycle pulses away from the clock edge.

// File: rtl/dqs_pkg.sv
package dqs_pkg;

    localparam int STATUS_W = 5;

    typedef enum logic [1:0] {
        Q1_IDLE   = 2'b00,
        Q1_PAUSED = 2'b01,
        Q1_ACTIVE = 2'b10
    } q1_state_e;

    typedef enum logic [2:0] {
        Q2_IDLE   = 3'b000,
        Q2_PAUSED = 3'b001,
        Q2_ACTIVE = 3'b010,
        Q2_SUSP   = 3'b011,
        Q2_TPEND  = 3'b100
    } q2_state_e;

    typedef enum logic {
        SEL_Q1 = 1'b0,
        SEL_Q2 = 1'b1
    } qsel_e;

    typedef struct packed {
        logic pause;
        logic eoq;
    } cmd_flags_t;

    function automatic logic [STATUS_W-1:0] pack_status(q1_state_e s1, q2_state_e s2);
        return {s1, s2};
    endfunction

endpackage

// File: rtl/dqs_cmd_ptr.sv
module dqs_cmd_ptr #(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic             eoq,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= eoq ? '0 : ptr + 1'b1;
        end
    end

    assert_eoq_rewind_R4: assert property (@(posedge clk) disable iff (rst)
        (adv && eoq && !clr) |=> (ptr == '0));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && !eoq && !clr) |=> (ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/dqs_q1_ctrl.sv
module dqs_q1_ctrl
    import dqs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop,
    input  logic       trig,
    input  logic       mode_en,
    input  logic       done,
    input  cmd_flags_t flags,
    output q1_state_e  state,
    output logic       take,
    output logic       leave
);
    assign take  = trig && mode_en && !stop && (state != Q1_ACTIVE);
    assign leave = (state == Q1_ACTIVE) && done && (flags.pause || flags.eoq);

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            state <= Q1_IDLE;
        end else if (take) begin
            state <= Q1_ACTIVE;
        end else if (state == Q1_ACTIVE && done) begin
            if (flags.eoq)        state <= Q1_IDLE;
            else if (flags.pause) state <= Q1_PAUSED;
        end
    end

    assert_no_done_when_inactive_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == Q1_ACTIVE));

endmodule

// File: rtl/dqs_q2_ctrl.sv
module dqs_q2_ctrl
    import dqs_pkg::*;
#(
    parameter int HAND_LAT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stop,
    input  logic       trig,
    input  logic       mode_en,
    input  logic       done,
    input  cmd_flags_t flags,
    input  logic       q1_active,
    input  logic       q1_take,
    input  logic       q1_leave,
    output q2_state_e  state
);
    localparam int HC_W = $clog2(HAND_LAT) + 1;

    logic [HC_W-1:0] hcnt;
    logic            accept;
    logic            q1_busy;

    assign accept  = trig && mode_en && !stop &&
                     (state == Q2_IDLE || state == Q2_PAUSED);
    assign q1_busy = q1_active || q1_take;

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            state <= Q2_IDLE;
            hcnt  <= '0;
        end else begin
            unique case (state)
                Q2_IDLE, Q2_PAUSED: begin
                    hcnt <= '0;
                    if (accept) state <= q1_busy ? Q2_TPEND : Q2_ACTIVE;
                end
                Q2_ACTIVE: begin
                    if (q1_take) begin
                        state <= Q2_SUSP;
                    end else if (done) begin
                        if (flags.eoq)        state <= Q2_IDLE;
                        else if (flags.pause) state <= Q2_PAUSED;
                    end
                end
                Q2_SUSP: begin
                    if (q1_leave) state <= Q2_ACTIVE;
                end
                Q2_TPEND: begin
                    if (q1_busy) begin
                        hcnt <= '0;
                    end else if (hcnt == HC_W'(HAND_LAT - 1)) begin
                        hcnt  <= '0;
                        state <= Q2_ACTIVE;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                default: state <= Q2_IDLE;
            endcase
        end
    end

    assert_susp_needs_q1_R5: assert property (@(posedge clk) disable iff (rst)
        (state == Q2_SUSP) |-> q1_active);

    assert_handover_gap_R8: assert property (@(posedge clk) disable iff (rst)
        (state == Q2_ACTIVE && $past(state) == Q2_TPEND) |->
            (!$past(q1_active) && !$past(q1_active, 2)));

endmodule

// File: rtl/dqs_conv_track.sv
module dqs_conv_track
    import dqs_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop,
    input  logic             q1_active,
    input  logic             q2_active,
    input  logic             q1_take,
    input  logic [PTR_W-1:0] q1_ptr,
    input  logic [PTR_W-1:0] q2_ptr,
    input  logic             conv_done,
    output logic             conv_start,
    output qsel_e            conv_qsel,
    output logic [PTR_W-1:0] conv_ptr,
    output logic             conv_abort,
    output logic             done_q1,
    output logic             done_q2
);
    logic  busy;
    qsel_e owner;
    logic  start_q1, start_q2;

    assign start_q1   = !busy && q1_active;
    assign start_q2   = !busy && q2_active && !q1_take;
    assign conv_start = (start_q1 || start_q2) && !stop;
    assign conv_qsel  = start_q1 ? SEL_Q1 : SEL_Q2;
    assign conv_ptr   = start_q1 ? q1_ptr : q2_ptr;
    assign conv_abort = busy && (stop || (owner == SEL_Q2 && q1_take));
    assign done_q1    = conv_done && busy && !conv_abort && owner == SEL_Q1;
    assign done_q2    = conv_done && busy && !conv_abort && owner == SEL_Q2;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            owner <= SEL_Q1;
        end else if (conv_abort || stop) begin
            busy <= 1'b0;
        end else if (conv_start) begin
            busy  <= 1'b1;
            owner <= conv_qsel;
        end else if (conv_done && busy) begin
            busy <= 1'b0;
        end
    end

    assert_single_start_R12: assert property (@(posedge clk) disable iff (rst)
        (conv_start && !stop) |=> !conv_start);

endmodule

// File: rtl/dual_queue_sched.sv
module dual_queue_sched
    import dqs_pkg::*;
#(
    parameter int PTR_W    = 4,
    parameter int HAND_LAT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop,
    input  logic             q1_mode_en,
    input  logic             q1_trig,
    input  logic             q1_cmd_pause,
    input  logic             q1_cmd_eoq,
    input  logic             q2_mode_en,
    input  logic             q2_trig,
    input  logic             q2_cmd_pause,
    input  logic             q2_cmd_eoq,
    input  logic             conv_done,
    output logic [PTR_W-1:0] q1_ptr,
    output logic [PTR_W-1:0] q2_ptr,
    output logic             conv_start,
    output logic             conv_qsel,
    output logic [PTR_W-1:0] conv_ptr,
    output logic             conv_abort,
    output logic [4:0]       queue_status
);
    localparam int NQ = 2;

    q1_state_e  s1;
    q2_state_e  s2;
    cmd_flags_t f1, f2;
    logic       q1_take, q1_leave;
    logic       done_q1, done_q2;
    qsel_e      sel;

    logic [NQ-1:0]    adv_v, eoq_v;
    logic [PTR_W-1:0] ptr_v [NQ];

    assign f1 = '{pause: q1_cmd_pause, eoq: q1_cmd_eoq};
    assign f2 = '{pause: q2_cmd_pause, eoq: q2_cmd_eoq};

    assign adv_v = {done_q2, done_q1};
    assign eoq_v = {q2_cmd_eoq, q1_cmd_eoq};

    for (genvar gi = 0; gi < NQ; gi++) begin : g_ptr
        dqs_cmd_ptr #(.PTR_W(PTR_W)) u_ptr (
            .clk (clk),
            .rst (rst),
            .clr (stop),
            .adv (adv_v[gi]),
            .eoq (eoq_v[gi]),
            .ptr (ptr_v[gi])
        );
    end

    assign q1_ptr = ptr_v[0];
    assign q2_ptr = ptr_v[1];

    dqs_q1_ctrl u_q1 (
        .clk     (clk),
        .rst     (rst),
        .stop    (stop),
        .trig    (q1_trig),
        .mode_en (q1_mode_en),
        .done    (done_q1),
        .flags   (f1),
        .state   (s1),
        .take    (q1_take),
        .leave   (q1_leave)
    );

    dqs_q2_ctrl #(.HAND_LAT(HAND_LAT)) u_q2 (
        .clk       (clk),
        .rst       (rst),
        .stop      (stop),
        .trig      (q2_trig),
        .mode_en   (q2_mode_en),
        .done      (done_q2),
        .flags     (f2),
        .q1_active (s1 == Q1_ACTIVE),
        .q1_take   (q1_take),
        .q1_leave  (q1_leave),
        .state     (s2)
    );

    dqs_conv_track #(.PTR_W(PTR_W)) u_conv (
        .clk        (clk),
        .rst        (rst),
        .stop       (stop),
        .q1_active  (s1 == Q1_ACTIVE),
        .q2_active  (s2 == Q2_ACTIVE),
        .q1_take    (q1_take),
        .q1_ptr     (ptr_v[0]),
        .q2_ptr     (ptr_v[1]),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_qsel  (sel),
        .conv_ptr   (conv_ptr),
        .conv_abort (conv_abort),
        .done_q1    (done_q1),
        .done_q2    (done_q2)
    );

    assign conv_qsel    = sel;
    assign queue_status = pack_status(s1, s2);

    assert_one_active_R2: assert property (@(posedge clk) disable iff (rst)
        !(queue_status[4:3] == 2'b10 && queue_status[2:0] == 3'b010));

    assert_no_q2_start_pending_R8: assert property (@(posedge clk) disable iff (rst)
        (queue_status[2:0] == 3'b100) |-> !(conv_start && conv_qsel));

    assert_abort_suspends_R5: assert property (@(posedge clk) disable iff (rst)
        (conv_abort && !stop) |=> (queue_status == 5'b10_011));

    assert_stop_clears_R10: assert property (@(posedge clk) disable iff (rst)
        stop |=> (queue_status == 5'b00_000 && q1_ptr == '0 && q2_ptr == '0));

endmodule

// File: tb/dual_queue_sched_tb.sv
`timescale 1ns/1ps
module dual_queue_sched_tb;
    localparam int PTR_W = 4;
    localparam int DEPTH = 1 << PTR_W;
    localparam int CONV_LAT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop = 1'b0;
    logic q1_mode_en = 1'b1, q1_trig = 1'b0, q2_mode_en = 1'b1, q2_trig = 1'b0;
    logic q1_cmd_pause, q1_cmd_eoq, q2_cmd_pause, q2_cmd_eoq;
    logic conv_done = 1'b0;
    logic [PTR_W-1:0] q1_ptr, q2_ptr, conv_ptr;
    logic conv_start, conv_qsel, conv_abort;
    logic [4:0] queue_status;

    logic t1_pause [DEPTH];
    logic t1_eoq   [DEPTH];
    logic t2_pause [DEPTH];
    logic t2_eoq   [DEPTH];

    int n_checks = 0, n_fail = 0;
    int n_start = 0, n_q2_start = 0, n_abort = 0, both_active = 0;
    int last_ptr = 0, cnt = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dual_queue_sched #(.PTR_W(PTR_W), .HAND_LAT(2)) u_dut (
        .clk(clk), .rst(rst), .stop(stop),
        .q1_mode_en(q1_mode_en), .q1_trig(q1_trig),
        .q1_cmd_pause(q1_cmd_pause), .q1_cmd_eoq(q1_cmd_eoq),
        .q2_mode_en(q2_mode_en), .q2_trig(q2_trig),
        .q2_cmd_pause(q2_cmd_pause), .q2_cmd_eoq(q2_cmd_eoq),
        .conv_done(conv_done),
        .q1_ptr(q1_ptr), .q2_ptr(q2_ptr),
        .conv_start(conv_start), .conv_qsel(conv_qsel), .conv_ptr(conv_ptr),
        .conv_abort(conv_abort), .queue_status(queue_status)
    );

    always_comb begin
        q1_cmd_pause = t1_pause[q1_ptr];
        q1_cmd_eoq   = t1_eoq[q1_ptr];
        q2_cmd_pause = t2_pause[q2_ptr];
        q2_cmd_eoq   = t2_eoq[q2_ptr];
    end

    // converter model and start/abort log
    always @(posedge clk) begin
        if (rst) begin
            cnt <= 0;
            conv_done <= 1'b0;
        end else begin
            conv_done <= 1'b0;
            if (conv_abort || stop) begin
                cnt <= 0;
            end else if (conv_start) begin
                cnt <= CONV_LAT;
            end else if (cnt > 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) conv_done <= 1'b1;
            end
            if (conv_start) begin
                n_start  <= n_start + 1;
                last_ptr <= int'(conv_ptr);
                if (conv_qsel) n_q2_start <= n_q2_start + 1;
            end
            if (conv_abort) n_abort <= n_abort + 1;
        end
    end

    always @(negedge clk)
        if (!rst && queue_status[4:3] == 2'b10 && queue_status[2:0] == 3'b010)
            both_active <= both_active + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    task automatic clear_tables();
        for (int i = 0; i < DEPTH; i++) begin
            t1_pause[i] = 1'b0; t1_eoq[i] = 1'b0;
            t2_pause[i] = 1'b0; t2_eoq[i] = 1'b0;
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_q1(input logic mode);
        @(negedge clk); q1_trig = 1'b1; q1_mode_en = mode;
        @(negedge clk); q1_trig = 1'b0; q1_mode_en = 1'b1;
    endtask

    task automatic pulse_q2(input logic mode);
        @(negedge clk); q2_trig = 1'b1; q2_mode_en = mode;
        @(negedge clk); q2_trig = 1'b0; q2_mode_en = 1'b1;
    endtask

    task automatic wait_q1_not(input logic [1:0] v);
        for (int i = 0; i < 200 && queue_status[4:3] == v; i++) @(negedge clk);
    endtask

    task automatic wait_q2_not(input logic [2:0] v);
        for (int i = 0; i < 200 && queue_status[2:0] == v; i++) @(negedge clk);
    endtask

    task automatic test_reset();
        chk(queue_status == 5'b00_000, "R11 reset status", queue_status, 0);
        chk(conv_start == 1'b0, "R12 no start at reset", conv_start, 0);
        chk(q1_ptr == 0 && q2_ptr == 0, "R11 reset pointers", {q1_ptr, q2_ptr}, 0);
    endtask

    task automatic test_q1_run();
        int n0;
        clear_tables(); t1_eoq[2] = 1'b1;
        n0 = n_start;
        pulse_q1(1'b1);
        chk(queue_status[4:3] == 2'b10, "R1 q1 active after trigger", queue_status[4:3], 2);
        wait_q1_not(2'b10);
        chk(n_start - n0 == 3, "R12 q1 start count", n_start - n0, 3);
        chk(last_ptr == 2, "R12 last conv_ptr", last_ptr, 2);
        chk(q1_ptr == 0 && queue_status == 5'b00_000, "R4 eoq rewinds and idles",
            {q1_ptr, queue_status}, 0);
    endtask

    task automatic test_pause();
        int n0;
        clear_tables(); t1_pause[1] = 1'b1; t1_eoq[3] = 1'b1;
        n0 = n_start;
        pulse_q1(1'b1);
        wait_q1_not(2'b10);
        chk(queue_status == 5'b01_000, "R3 q1 paused", queue_status, 5'b01_000);
        chk(q1_ptr == 2, "R3 pointer advanced", q1_ptr, 2);
        pulse_q1(1'b0);
        idle_cycles(4);
        chk(queue_status == 5'b01_000 && n_start - n0 == 2, "R1 trigger without mode ignored",
            queue_status, 5'b01_000);
        pulse_q1(1'b1);
        wait_q1_not(2'b10);
        chk(n_start - n0 == 4 && last_ptr == 3, "R3 resume at next entry", last_ptr, 3);
        chk(queue_status == 5'b00_000, "R4 idle after resume", queue_status, 0);
    endtask

    task automatic test_handover();
        int q2n;
        clear_tables(); t1_eoq[1] = 1'b1; t2_eoq[0] = 1'b1;
        pulse_q1(1'b1);
        pulse_q2(1'b1);
        chk(queue_status == 5'b10_100, "R7 q2 trigger pending", queue_status, 5'b10_100);
        wait_q1_not(2'b10);
        q2n = n_q2_start;
        chk(queue_status == 5'b00_100, "R8 pending cycle 1", queue_status, 5'b00_100);
        @(negedge clk);
        chk(queue_status == 5'b00_100, "R8 pending cycle 2", queue_status, 5'b00_100);
        @(negedge clk);
        chk(queue_status == 5'b00_010, "R8 q2 active after 2 cycles", queue_status, 5'b00_010);
        chk(n_q2_start == q2n, "R8 no q2 start during handover", n_q2_start - q2n, 0);
        wait_q2_not(3'b010);
        chk(queue_status == 5'b00_000, "R4 q2 eoq idle", queue_status, 0);
    endtask

    task automatic test_abort();
        int b, a0;
        clear_tables(); t2_eoq[3] = 1'b1; t1_eoq[0] = 1'b1;
        b = n_q2_start; a0 = n_abort;
        pulse_q2(1'b1);
        for (int i = 0; i < 100 && n_q2_start < b + 2; i++) @(negedge clk);
        pulse_q1(1'b1);
        chk(queue_status == 5'b10_011, "R5 q1 active q2 suspended", queue_status, 5'b10_011);
        chk(n_abort == a0 + 1, "R5 abort pulsed", n_abort - a0, 1);
        wait_q1_not(2'b10);
        chk(queue_status == 5'b00_010, "R6 q2 resumes at once", queue_status, 5'b00_010);
        for (int i = 0; i < 20 && n_q2_start < b + 3; i++) @(negedge clk);
        chk(last_ptr == 1, "R6 restart aborted word", last_ptr, 1);
        wait_q2_not(3'b010);
        chk(n_q2_start - b == 5, "R6 q2 start count", n_q2_start - b, 5);
    endtask

    task automatic test_retrigger();
        int n0;
        clear_tables(); t1_eoq[3] = 1'b1;
        n0 = n_start;
        pulse_q1(1'b1);
        idle_cycles(4);
        pulse_q1(1'b1);
        wait_q1_not(2'b10);
        chk(n_start - n0 == 4 && last_ptr == 3, "R9 retrigger ignored", n_start - n0, 4);
    endtask

    task automatic test_both_paused();
        clear_tables(); t1_pause[0] = 1'b1; t2_pause[0] = 1'b1;
        pulse_q1(1'b1);
        wait_q1_not(2'b10);
        pulse_q2(1'b1);
        wait_q2_not(3'b010);
        chk(queue_status == 5'b01_001, "R2 both paused", queue_status, 5'b01_001);
    endtask

    task automatic test_stop();
        int a0;
        t1_eoq[10] = 1'b1;
        a0 = n_abort;
        pulse_q1(1'b1);
        @(negedge clk);
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        chk(queue_status == 5'b00_000, "R10 stop clears status", queue_status, 0);
        chk(q1_ptr == 0 && q2_ptr == 0, "R10 stop rewinds pointers", {q1_ptr, q2_ptr}, 0);
        chk(n_abort == a0 + 1, "R10 stop aborts conversion", n_abort - a0, 1);
    endtask

    initial begin
        clear_tables();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_q1_run();
        test_pause();
        test_handover();
        test_abort();
        test_retrigger();
        test_both_paused();
        test_stop();
        chk(both_active == 0, "R2 never both active", both_active, 0);
        finished = 1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule